// File: doc/BRIEF.md
# Descriptor Ring Copy Engine

A single-channel copy engine fed by two rings of descriptors held in memory. Software fills source descriptors with a buffer address, a byte count and a flags word. It posts empty destination buffers through destination descriptors. It hands entries to the engine by advancing a write index for each ring through a 32-bit register port. Whenever both rings hold work and no halt is requested, the engine takes one source and one destination descriptor. It copies the data word by word through a simple memory request port and writes a completion word back into the destination descriptor. Then it advances both hardware read indices.

Sticky interrupt status records completions, ring watermark crossings and faults. A single interrupt line is the OR of every enabled status bit. A halt command stops new work after the current descriptor and reports when the engine has gone quiet.

Top module: `ring_copy_engine`

## Requirements
- R1: After reset every register reads zero and `irq` is low. Ring bases (0x00 source, 0x08 destination), ring entry counts (0x04, 0x0C), control (0x10) and watermarks (0x4C, 0x50) read back what was written. Control bits 15:0 hold the length limit, bit 16 the data swap enable and bit 17 the completion-word swap enable.
- R2: A source descriptor holds the buffer address in word 0 and {flags[15:0], byte count[15:0]} in word 1. A destination descriptor holds the target buffer address in word 0. The engine copies ceil(count/4) 32-bit words from the source buffer to the target buffer. Words past that count are not touched. Then it writes {flags, count} into word 1 of the destination descriptor. Flag bits 15:2 pass through unchanged.
- R3: Descriptor i of a ring lies at base + 8*i. Read indices advance as (i+1) AND (entries-1) and can be read at 0x44 (source) and 0x48 (destination). One source and one destination entry are consumed per descriptor. Work starts only when both occupancies, (write - read) AND (entries-1), are non-zero.
- R4: A write to the source (0x3C) or destination (0x40) write index whose new occupancy would be smaller than the current one is rejected. The stored index is kept, and misc status bit 5 (source) or bit 6 (destination) is set.
- R5: Data words are byte-reversed when flag bit 1 or control bit 16 is set. The completion word is byte-reversed when control bit 17 is set.
- R6: Host status bit 0 is set when a descriptor completes without error and flag bit 0 (gather fragment) is clear. A gather fragment completes without setting it.
- R7: Faults consume both descriptors, copy no data and write no completion word. The bits are: bit 10, a memory read returned an error during descriptor fetch; bit 8, byte count is zero; bit 7, count exceeds control bits 15:0; bit 9, target address not a multiple of 4. They are listed in priority order, and only the first that applies is recorded.
- R8: Host status bit 1 (source) and bit 3 (destination) are set when ring occupancy rises above the high threshold (watermark bits 15:0). Bit 2 (source) and bit 4 (destination) are set when occupancy falls below the low threshold (bits 31:16).
- R9: Command bit 0 at 0x18 requests a halt. The descriptor in progress finishes and no new one starts. Command bit 3 reads 1 once the engine is idle under halt, and no memory request is made then. Clearing bit 0 resumes processing.
- R10: Host status (0x30) and misc status (0x38) bits are sticky and cleared by writing 1. `irq` is the OR of host status AND host enable (0x2C) with misc status AND misc enable (0x34).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_addr) |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 32 | Memory byte address, word aligned |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Read data, returned the cycle after the request |
| mem_err | input | 1 | Read error, returned with mem_rdata |
| irq | output | 1 | Interrupt request |

## Verification
Register reads are combinational and are sampled within the same cycle. Index, control and status writes take effect at the next clock edge, so the bench reads them back one cycle after the strobe. How long a descriptor takes depends on its length: four fetch cycles, then two cycles per word, then writeback and retire. So the bench does not count cycles. It polls the source read index until it reaches the posted value and only then compares memory and status. Halt is checked by holding posted work for a fixed idle window while the read index stays put.

// File: rtl/ce_pkg.sv
package ce_pkg;
    parameter int IDX_W = 16;
    parameter int AW    = 32;
    parameter int DW    = 32;
    parameter int RAW   = 8;

    typedef logic [IDX_W-1:0] idx_t;

    localparam logic [RAW-1:0] A_SRC_BASE = 8'h00;
    localparam logic [RAW-1:0] A_SRC_SIZE = 8'h04;
    localparam logic [RAW-1:0] A_DST_BASE = 8'h08;
    localparam logic [RAW-1:0] A_DST_SIZE = 8'h0C;
    localparam logic [RAW-1:0] A_CTRL     = 8'h10;
    localparam logic [RAW-1:0] A_CMD      = 8'h18;
    localparam logic [RAW-1:0] A_HOST_IE  = 8'h2C;
    localparam logic [RAW-1:0] A_HOST_IS  = 8'h30;
    localparam logic [RAW-1:0] A_MISC_IE  = 8'h34;
    localparam logic [RAW-1:0] A_MISC_IS  = 8'h38;
    localparam logic [RAW-1:0] A_SRC_WR   = 8'h3C;
    localparam logic [RAW-1:0] A_DST_WR   = 8'h40;
    localparam logic [RAW-1:0] A_SRC_RD   = 8'h44;
    localparam logic [RAW-1:0] A_DST_RD   = 8'h48;
    localparam logic [RAW-1:0] A_SRC_WM   = 8'h4C;
    localparam logic [RAW-1:0] A_DST_WM   = 8'h50;

    typedef enum logic [3:0] {
        MV_IDLE, MV_SDESC0, MV_SDESC1, MV_DDESC0, MV_CHECK,
        MV_RD, MV_WR, MV_WB, MV_FIN
    } mv_state_t;

    typedef struct packed {
        logic [15:0] flags;
        logic [15:0] nbytes;
    } desc_meta_t;

    typedef struct packed {
        logic complete;
        logic maxlen;
        logic srclen;
        logic dstaddr;
        logic buserr;
    } mv_evt_t;

    function automatic idx_t ring_delta(idx_t mask, idx_t from_i, idx_t to_i);
        return (to_i - from_i) & mask;
    endfunction

    function automatic idx_t ring_next(idx_t mask, idx_t i);
        return (i + idx_t'(1)) & mask;
    endfunction

    function automatic logic [31:0] bswap32(logic [31:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction
endpackage

// File: rtl/ce_ring_track.sv
module ce_ring_track
    import ce_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  idx_t size,
    input  logic wr_set,
    input  idx_t wr_val,
    input  logic adv,
    input  idx_t wm_lo,
    input  idx_t wm_hi,
    output idx_t wr_idx,
    output idx_t rd_idx,
    output idx_t occ,
    output logic ovf,
    output logic wm_hi_hit,
    output logic wm_lo_hit
);
    idx_t mask, new_occ, prev_occ;

    assign mask    = size - idx_t'(1);
    assign occ     = ring_delta(mask, rd_idx, wr_idx);
    assign new_occ = ring_delta(mask, rd_idx, wr_val);
    assign ovf     = wr_set && (new_occ < occ);

    assign wm_hi_hit = (occ > wm_hi) && (prev_occ <= wm_hi);
    assign wm_lo_hit = (occ < wm_lo) && (prev_occ >= wm_lo);

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_idx   <= '0;
            rd_idx   <= '0;
            prev_occ <= '0;
        end else begin
            prev_occ <= occ;
            if (wr_set && !ovf)
                wr_idx <= wr_val & mask;
            if (adv)
                rd_idx <= ring_next(mask, rd_idx);
        end
    end
endmodule

// File: rtl/ce_mover.sv
module ce_mover
    import ce_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          go,
    input  logic          halt,
    input  logic [AW-1:0] src_base,
    input  logic [AW-1:0] dst_base,
    input  idx_t          src_rd,
    input  idx_t          dst_rd,
    input  logic [15:0]   max_len,
    input  logic          swap_data,
    input  logic          swap_wb,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    input  logic          mem_err,
    output logic          idle,
    output logic          adv,
    output mv_evt_t       fin_evt
);
    mv_state_t     st;
    desc_meta_t    meta;
    logic [AW-1:0] sbuf, dbuf, sdesc, ddesc;
    logic          err_acc;
    logic [15:0]   widx, nwords;
    mv_evt_t       evt_q;

    assign sdesc  = src_base + (AW'(src_rd) << 3);
    assign ddesc  = dst_base + (AW'(dst_rd) << 3);
    assign nwords = 16'((17'(meta.nbytes) + 17'd3) >> 2);
    assign idle   = (st == MV_IDLE);
    assign adv    = (st == MV_FIN);
    assign fin_evt = evt_q;

    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        case (st)
            MV_SDESC0: begin mem_req = 1'b1; mem_addr = sdesc; end
            MV_SDESC1: begin mem_req = 1'b1; mem_addr = sdesc + AW'(4); end
            MV_DDESC0: begin mem_req = 1'b1; mem_addr = ddesc; end
            MV_RD: begin
                mem_req  = 1'b1;
                mem_addr = {sbuf[AW-1:2], 2'b00} + (AW'(widx) << 2);
            end
            MV_WR: begin
                mem_req   = !mem_err;
                mem_we    = !mem_err;
                mem_addr  = dbuf + (AW'(widx) << 2);
                mem_wdata = (swap_data || meta.flags[1]) ? bswap32(mem_rdata) : mem_rdata;
            end
            MV_WB: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = ddesc + AW'(4);
                mem_wdata = swap_wb ? bswap32(meta) : meta;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= MV_IDLE;
            meta    <= '0;
            sbuf    <= '0;
            dbuf    <= '0;
            err_acc <= 1'b0;
            widx    <= '0;
            evt_q   <= '0;
        end else begin
            case (st)
                MV_IDLE: if (go && !halt) begin
                    st    <= MV_SDESC0;
                    evt_q <= '0;
                end
                MV_SDESC0: st <= MV_SDESC1;
                MV_SDESC1: begin
                    sbuf    <= mem_rdata;
                    err_acc <= mem_err;
                    st      <= MV_DDESC0;
                end
                MV_DDESC0: begin
                    meta    <= mem_rdata;
                    err_acc <= err_acc | mem_err;
                    st      <= MV_CHECK;
                end
                MV_CHECK: begin
                    dbuf <= mem_rdata;
                    widx <= '0;
                    st   <= MV_FIN;
                    if (err_acc || mem_err)          evt_q.buserr  <= 1'b1;
                    else if (meta.nbytes == 16'd0)   evt_q.srclen  <= 1'b1;
                    else if (meta.nbytes > max_len)  evt_q.maxlen  <= 1'b1;
                    else if (mem_rdata[1:0] != 2'b0) evt_q.dstaddr <= 1'b1;
                    else                             st <= MV_RD;
                end
                MV_RD: st <= MV_WR;
                MV_WR: begin
                    if (mem_err) begin
                        evt_q.buserr <= 1'b1;
                        st           <= MV_FIN;
                    end else begin
                        widx <= widx + 16'd1;
                        st   <= (widx + 16'd1 == nwords) ? MV_WB : MV_RD;
                    end
                end
                MV_WB: begin
                    evt_q.complete <= !meta.flags[0];
                    st             <= MV_FIN;
                end
                MV_FIN:  st <= MV_IDLE;
                default: st <= MV_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/ring_copy_engine.sv
module ring_copy_engine
    import ce_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           reg_wr,
    input  logic [RAW-1:0] reg_addr,
    input  logic [31:0]    reg_wdata,
    output logic [31:0]    reg_rdata,
    output logic           mem_req,
    output logic           mem_we,
    output logic [AW-1:0]  mem_addr,
    output logic [DW-1:0]  mem_wdata,
    input  logic [DW-1:0]  mem_rdata,
    input  logic           mem_err,
    output logic           irq
);
    logic [AW-1:0] src_base_q, dst_base_q;
    idx_t          src_size_q, dst_size_q;
    logic [17:0]   ctrl_q;
    logic          halt_q;
    logic [4:0]    host_ie_q, host_is_q;
    logic [5:0]    misc_ie_q, misc_is_q;
    logic [31:0]   src_wm_q, dst_wm_q;

    idx_t    src_wr_idx, src_rd_idx, src_occ, dst_wr_idx, dst_rd_idx, dst_occ;
    logic    src_ovf, src_hi, src_lo, dst_ovf, dst_hi, dst_lo;
    logic    mv_idle, mv_adv, halt_stat;
    mv_evt_t mv_evt;
    logic [4:0] host_set, host_clr;
    logic [5:0] misc_set, misc_clr;

    ce_ring_track u_src_ring (
        .clk(clk), .rst(rst), .size(src_size_q),
        .wr_set(reg_wr && reg_addr == A_SRC_WR), .wr_val(reg_wdata[IDX_W-1:0]),
        .adv(mv_adv), .wm_lo(idx_t'(src_wm_q[31:16])), .wm_hi(idx_t'(src_wm_q[15:0])),
        .wr_idx(src_wr_idx), .rd_idx(src_rd_idx), .occ(src_occ),
        .ovf(src_ovf), .wm_hi_hit(src_hi), .wm_lo_hit(src_lo)
    );

    ce_ring_track u_dst_ring (
        .clk(clk), .rst(rst), .size(dst_size_q),
        .wr_set(reg_wr && reg_addr == A_DST_WR), .wr_val(reg_wdata[IDX_W-1:0]),
        .adv(mv_adv), .wm_lo(idx_t'(dst_wm_q[31:16])), .wm_hi(idx_t'(dst_wm_q[15:0])),
        .wr_idx(dst_wr_idx), .rd_idx(dst_rd_idx), .occ(dst_occ),
        .ovf(dst_ovf), .wm_hi_hit(dst_hi), .wm_lo_hit(dst_lo)
    );

    ce_mover u_mover (
        .clk(clk), .rst(rst),
        .go(src_occ != '0 && dst_occ != '0), .halt(halt_q),
        .src_base(src_base_q), .dst_base(dst_base_q),
        .src_rd(src_rd_idx), .dst_rd(dst_rd_idx),
        .max_len(ctrl_q[15:0]), .swap_data(ctrl_q[16]), .swap_wb(ctrl_q[17]),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_err(mem_err),
        .idle(mv_idle), .adv(mv_adv), .fin_evt(mv_evt)
    );

    assign halt_stat = halt_q && mv_idle;
    assign host_set  = {dst_lo, dst_hi, src_lo, src_hi, mv_adv && mv_evt.complete};
    assign misc_set  = {mv_adv && mv_evt.buserr, mv_adv && mv_evt.dstaddr,
                        mv_adv && mv_evt.srclen, mv_adv && mv_evt.maxlen,
                        dst_ovf, src_ovf};
    assign host_clr  = (reg_wr && reg_addr == A_HOST_IS) ? reg_wdata[4:0]  : '0;
    assign misc_clr  = (reg_wr && reg_addr == A_MISC_IS) ? reg_wdata[10:5] : '0;
    assign irq       = (|(host_is_q & host_ie_q)) || (|(misc_is_q & misc_ie_q));

    always_ff @(posedge clk) begin
        if (rst) begin
            src_base_q <= '0; dst_base_q <= '0;
            src_size_q <= '0; dst_size_q <= '0;
            ctrl_q     <= '0; halt_q     <= 1'b0;
            host_ie_q  <= '0; host_is_q  <= '0;
            misc_ie_q  <= '0; misc_is_q  <= '0;
            src_wm_q   <= '0; dst_wm_q   <= '0;
        end else begin
            host_is_q <= (host_is_q & ~host_clr) | host_set;
            misc_is_q <= (misc_is_q & ~misc_clr) | misc_set;
            if (reg_wr) begin
                case (reg_addr)
                    A_SRC_BASE: src_base_q <= reg_wdata;
                    A_SRC_SIZE: src_size_q <= reg_wdata[IDX_W-1:0];
                    A_DST_BASE: dst_base_q <= reg_wdata;
                    A_DST_SIZE: dst_size_q <= reg_wdata[IDX_W-1:0];
                    A_CTRL:     ctrl_q     <= reg_wdata[17:0];
                    A_CMD:      halt_q     <= reg_wdata[0];
                    A_HOST_IE:  host_ie_q  <= reg_wdata[4:0];
                    A_MISC_IE:  misc_ie_q  <= reg_wdata[10:5];
                    A_SRC_WM:   src_wm_q   <= reg_wdata;
                    A_DST_WM:   dst_wm_q   <= reg_wdata;
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_SRC_BASE: reg_rdata = src_base_q;
            A_SRC_SIZE: reg_rdata = 32'(src_size_q);
            A_DST_BASE: reg_rdata = dst_base_q;
            A_DST_SIZE: reg_rdata = 32'(dst_size_q);
            A_CTRL:     reg_rdata = 32'(ctrl_q);
            A_CMD:      reg_rdata = {28'b0, halt_stat, 2'b00, halt_q};
            A_HOST_IE:  reg_rdata = 32'(host_ie_q);
            A_HOST_IS:  reg_rdata = 32'(host_is_q);
            A_MISC_IE:  reg_rdata = {21'b0, misc_ie_q, 5'b0};
            A_MISC_IS:  reg_rdata = {21'b0, misc_is_q, 5'b0};
            A_SRC_WR:   reg_rdata = 32'(src_wr_idx);
            A_DST_WR:   reg_rdata = 32'(dst_wr_idx);
            A_SRC_RD:   reg_rdata = 32'(src_rd_idx);
            A_DST_RD:   reg_rdata = 32'(dst_rd_idx);
            A_SRC_WM:   reg_rdata = src_wm_q;
            A_DST_WM:   reg_rdata = dst_wm_q;
            default: ;
        endcase
    end
endmodule

// File: rtl/ce_checks.sv
module ce_checks
    import ce_pkg::*;
(
    input logic           clk,
    input logic           rst,
    input logic           mem_req,
    input logic [AW-1:0]  mem_addr,
    input logic           reg_wr,
    input logic [RAW-1:0] reg_addr,
    input logic [31:0]    reg_wdata,
    input logic           halt_stat,
    input logic           mv_adv,
    input idx_t           src_occ,
    input idx_t           dst_occ,
    input idx_t           src_wr_idx,
    input logic [4:0]     host_is_q
);
    // R2: every memory access is word aligned
    p_word_aligned_r2: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (mem_addr[1:0] == 2'b00));

    // R9: no memory traffic while halt status is reported
    p_halt_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        halt_stat |-> !mem_req);

    // R3: a descriptor is retired only while both rings hold entries
    p_consume_nonempty_r3: assert property (@(posedge clk) disable iff (rst)
        mv_adv |-> (src_occ != '0 && dst_occ != '0));

    // R4: the source write index moves only on a write to its register
    p_wr_idx_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !(reg_wr && reg_addr == A_SRC_WR) |=> $stable(src_wr_idx));

    // R10: copy-complete stays set until a write of 1 clears it
    p_sticky_done_r10: assert property (@(posedge clk) disable iff (rst)
        (host_is_q[0] && !(reg_wr && reg_addr == A_HOST_IS && reg_wdata[0])) |=> host_is_q[0]);
endmodule

bind ring_copy_engine ce_checks u_checks (
    .clk(clk), .rst(rst), .mem_req(mem_req), .mem_addr(mem_addr),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .halt_stat(halt_stat), .mv_adv(mv_adv), .src_occ(src_occ), .dst_occ(dst_occ),
    .src_wr_idx(src_wr_idx), .host_is_q(host_is_q)
);

// File: tb/ring_copy_engine_test.sv
module ring_copy_engine_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        mem_err = 1'b0;
    logic        irq;

    logic        bw_en = 1'b0;
    logic [31:0] bw_addr = '0, bw_data = '0;
    logic [31:0] err_addr = 32'hFFFF_FFFF;
    logic [31:0] mem [0:1023];

    int n_chk = 0, n_fail = 0;
    int s_wr = 0, d_wr = 0, d_rd = 0;
    logic ctl_sd = 1'b0, ctl_sw = 1'b0;
    logic [31:0] srcw [0:16];
    logic [31:0] rv;

    localparam logic [31:0] SRC_RING = 32'h100;
    localparam logic [31:0] DST_RING = 32'h200;

    always #5 clk = ~clk;

    ring_copy_engine uut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_err(mem_err), .irq(irq)
    );

    always @(posedge clk) begin
        if (mem_req) begin
            if (mem_we) mem[mem_addr[11:2]] <= mem_wdata;
            else begin
                mem_rdata <= mem[mem_addr[11:2]];
                mem_err   <= (mem_addr == err_addr);
            end
        end else begin
            mem_err <= 1'b0;
        end
        if (bw_en) mem[bw_addr[11:2]] <= bw_data;
    end

    function automatic logic [31:0] bsw(logic [31:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk); reg_addr = a; #1; d = reg_rdata;
    endtask

    task automatic mw(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk); bw_en = 1'b1; bw_addr = a; bw_data = d;
        @(negedge clk); bw_en = 1'b0;
    endtask

    task automatic wait_src(input int target);
        logic [31:0] v;
        for (int i = 0; i < 500; i++) begin
            rd(8'h44, v);
            if (v == 32'(target)) break;
        end
        check("R3 source read index after completion", v, 32'(target));
    endtask

    task automatic set_ctrl(input logic sd, input logic sw);
        ctl_sd = sd; ctl_sw = sw;
        wr(8'h10, {14'b0, sw, sd, 16'd64});
    endtask

    // one descriptor; exp_misc==0 means a normal copy
    task automatic run_desc(input int nb, input logic [15:0] flags,
                            input logic [31:0] exp_misc, input int dst_off, input logic bus);
        int slot = s_wr;
        int nw = (nb + 3) / 4;
        logic [31:0] sbuf = 32'h400 + 32'(slot) * 32'h100;
        logic [31:0] dbuf = 32'h800 + 32'(d_rd) * 32'h100;
        logic [31:0] meta = {flags, 16'(nb)};
        logic [31:0] v;
        logic swp = flags[1] | ctl_sd;
        for (int j = 0; j < nw; j++) begin
            srcw[j] = $urandom;
            mw(sbuf + 32'(j) * 4, srcw[j]);
        end
        for (int j = 0; j <= nw; j++) mw(dbuf + 32'(j) * 4, 32'hDEAD_0000 + 32'(j));
        mw(SRC_RING + 32'(slot) * 8, sbuf);
        mw(SRC_RING + 32'(slot) * 8 + 4, meta);
        if (dst_off != 0) mw(DST_RING + 32'(d_rd) * 8, dbuf + 32'(dst_off));
        if (bus) err_addr = SRC_RING + 32'(slot) * 8;
        d_wr = (d_wr + 1) & 3;
        wr(8'h40, 32'(d_wr));
        s_wr = (s_wr + 1) & 3;
        wr(8'h3C, 32'(s_wr));
        wait_src(s_wr);
        err_addr = 32'hFFFF_FFFF;
        if (dst_off != 0) mw(DST_RING + 32'(d_rd) * 8, dbuf);
        rd(8'h48, v);
        check("R3 destination read index", v, 32'((d_rd + 1) & 3));
        if (exp_misc == 0) begin
            for (int j = 0; j < nw; j++)
                check("R2/R5 copied word", mem[dbuf[11:2] + 10'(j)], swp ? bsw(srcw[j]) : srcw[j]);
            check("R2 word past count untouched", mem[dbuf[11:2] + 10'(nw)], 32'hDEAD_0000 + 32'(nw));
            check("R2/R5 completion word", mem[DST_RING[11:2] + 10'(d_rd * 2 + 1)],
                  ctl_sw ? bsw(meta) : meta);
            rd(8'h30, v);
            check("R6 copy-complete vs gather", 32'(v[0]), 32'(!flags[0]));
            rd(8'h38, v);
            check("R7 no fault on good descriptor", v, 32'h0);
        end else begin
            check("R7 fault leaves target untouched", mem[dbuf[11:2]], 32'hDEAD_0000);
            rd(8'h38, v);
            check("R7 fault code", v, exp_misc);
            rd(8'h30, v);
            check("R7 no copy-complete on fault", 32'(v[0]), 32'h0);
        end
        d_rd = (d_rd + 1) & 3;
        wr(8'h30, 32'h1F);
        wr(8'h38, 32'h7E0);
    endtask

    task automatic finish_test();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        finish_test();
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        rd(8'h00, rv); check("R1 reset source base", rv, 0);
        rd(8'h30, rv); check("R1 reset host status", rv, 0);
        rd(8'h38, rv); check("R1 reset misc status", rv, 0);
        rd(8'h18, rv); check("R1 reset command", rv, 0);
        check("R1 reset irq", 32'(irq), 0);
        // configuration and readback
        wr(8'h00, SRC_RING); wr(8'h04, 4);
        wr(8'h08, DST_RING); wr(8'h0C, 4);
        wr(8'h4C, 32'h0000_FFFF); wr(8'h50, 32'h0000_FFFF);
        set_ctrl(1'b0, 1'b0);
        rd(8'h00, rv); check("R1 source base readback", rv, SRC_RING);
        rd(8'h0C, rv); check("R1 destination size readback", rv, 4);
        rd(8'h10, rv); check("R1 control readback", rv, 32'd64);
        rd(8'h50, rv); check("R1 watermark readback", rv, 32'h0000_FFFF);
        for (int i = 0; i < 4; i++) mw(DST_RING + 32'(i) * 8, 32'h800 + 32'(i) * 32'h100);

        // random copies, R2 R3 R5 R6
        for (int k = 0; k < 16; k++) begin
            if (k % 4 == 0) set_ctrl(k[2], k[3]);
            run_desc(1 + int'($urandom % 64), 16'($urandom), 0, 0, 1'b0);
        end
        set_ctrl(1'b0, 1'b0);

        // R9 halt, R4 overflow rejection, R8 watermarks
        wr(8'h18, 1);
        rd(8'h18, rv); check("R9 halt status", rv, 32'h9);
        wr(8'h4C, 32'h0002_0001); wr(8'h50, 32'h0002_0002);
        for (int i = 0; i < 2; i++) begin
            mw(SRC_RING + 32'((s_wr + i) & 3) * 8, 32'h400);
            mw(SRC_RING + 32'((s_wr + i) & 3) * 8 + 4, 32'h0000_0008);
        end
        wr(8'h3C, 32'((s_wr + 2) & 3));
        wr(8'h3C, 32'((s_wr + 1) & 3));
        rd(8'h3C, rv); check("R4 source write index kept", rv, 32'((s_wr + 2) & 3));
        rd(8'h38, rv); check("R4 source overflow bit 5", rv, 32'h20);
        wr(8'h40, 32'((d_wr + 3) & 3));
        wr(8'h40, 32'(d_wr));
        rd(8'h40, rv); check("R4 destination write index kept", rv, 32'((d_wr + 3) & 3));
        rd(8'h38, rv); check("R4 destination overflow bit 6", rv, 32'h60);
        repeat (20) @(negedge clk);
        rd(8'h44, rv); check("R9 no progress while halted", rv, 32'(s_wr));
        wr(8'h18, 0);
        s_wr = (s_wr + 2) & 3; d_rd = (d_rd + 2) & 3; d_wr = (d_wr + 3) & 3;
        wait_src(s_wr);
        rd(8'h18, rv); check("R9 resumed command", rv, 0);
        rd(8'h30, rv); check("R8 watermarks and completion", rv, 32'h1F);
        // R10 interrupt enables and W1C
        check("R10 irq masked", 32'(irq), 0);
        wr(8'h2C, 1);
        check("R10 irq from host", 32'(irq), 1);
        wr(8'h30, 32'h1F);
        rd(8'h30, rv); check("R10 host write-1-clear", rv, 0);
        check("R10 irq after clear", 32'(irq), 0);
        wr(8'h34, 32'h20);
        check("R10 irq from misc", 32'(irq), 1);
        wr(8'h38, 32'h7E0);
        check("R10 irq after misc clear", 32'(irq), 0);
        wr(8'h4C, 32'h0000_FFFF); wr(8'h50, 32'h0000_FFFF);

        // R7 faults
        run_desc(0, 16'h0, 32'h100, 0, 1'b0);
        run_desc(65, 16'h0, 32'h080, 0, 1'b0);
        run_desc(8, 16'h0, 32'h200, 2, 1'b0);
        run_desc(8, 16'h0, 32'h400, 0, 1'b1);
        run_desc(0, 16'h0, 32'h400, 0, 1'b1);
        run_desc(12, 16'h0004, 0, 0, 1'b0);
        finish_test();
    end
endmodule